// File: doc/BRIEF.md
# Double-Width Single-Port RAM

This block is a synchronous single-port memory whose data word is twice as wide as the word of the array that holds it. The user sees one clock, one enable, one write strobe, one address and a wide write-data bus, and gets registered read data back. Inside, the storage is one true dual-port array with half-width words. Both of its ports are driven in every access, so a single external access moves the whole wide word in one cycle.

Each internal port address is the external address with one extra bit added as the least significant bit. The lower half of the wide word uses the port whose extra bit is 0. The upper half uses the port whose extra bit is 1. An external depth of N words therefore needs an internal array of 2N half-width entries. The two ports always use different internal entries, so they never collide.

The read port is registered, and a write also updates the read data with the word being written (write-first). The storage is not cleared by reset. Reset clears only the read-data register.

Top module: `wide_sp_ram`

## Requirements
- R1: On an enabled cycle with the write strobe low, `rdata` shows the full word stored at `addr`, one clock edge after that address was presented.
- R2: On an enabled cycle with the write strobe high, the word on `wdata` is stored at `addr`. After the same clock edge `rdata` equals that new word, not the old contents.
- R3: While `en` is low, no location is written even when `we` is high, and `rdata` keeps its previous value.
- R4: Each external address holds a full independent word, bits 71..0. Writing one address leaves the contents of every other address unchanged, including both neighbours.
- R5: A clock edge with `rst_n` low sets `rdata` to all zeros. Stored words survive reset and can still be read afterwards.
- R6: Any mix of reads and writes may follow each other on consecutive cycles, each returning its R1/R2 result with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for storage and read register |
| rst_n | input | 1 | Synchronous active-low reset of the read-data register |
| en | input | 1 | Access enable; low means no write and read data holds |
| we | input | 1 | Write strobe, qualified by `en` |
| addr | input | 6 | Word address (log2 of DEPTH, default 64 words) |
| wdata | input | 72 | Word to write |
| rdata | output | 72 | Registered read data |

## Verification
Two functions meet in a single cycle here: the write into the array and the update of the read-data register. With write-first behaviour the register must take the incoming word, while the array entry it would otherwise have read is changing at the same edge. The bench writes a fresh value to an address that already holds a different known word, and in the same cycle expects `rdata` to show the new word. It then reads that address back. Enable-low cycles with the write strobe high are also mixed into the random traffic. These check that the attempted write neither lands in the array nor disturbs the held read data.

// File: rtl/wsr_pkg.sv
// Package: shared types for the double-width single-port RAM.
// Assumes exactly two internal lanes, one per port of the dual-port array.
package wsr_pkg;

    // Number of internal ports/lanes that together form one external word.
    localparam int NUM_LANES = 2;

    // Lane identity; the value equals the internal address LSB of that lane.
    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    // Internal address LSB used by a lane index.
    function automatic logic lane_sel_bit(input int lane);
        return (lane == 0) ? LANE_LO : LANE_HI;
    endfunction

endpackage

// File: rtl/wsr_dp_array.sv
// Module: true dual-port array with half-width words, single clock.
// Each port has its own enable, write strobe, address and write data.
// Read data is registered, write-first per port. Storage has no reset; the
// read registers clear on synchronous active-low reset.
// Assumes the two ports never write the same entry in one cycle.
module wsr_dp_array #(
    parameter int HALF_W  = 36,
    parameter int ENTRIES = 128,
    parameter int IAW     = $clog2(ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [wsr_pkg::NUM_LANES-1:0]     port_en,
    input  logic [wsr_pkg::NUM_LANES-1:0]     port_we,
    input  logic [wsr_pkg::NUM_LANES-1:0][IAW-1:0]    port_addr,
    input  logic [wsr_pkg::NUM_LANES-1:0][HALF_W-1:0] port_wd,
    output logic [wsr_pkg::NUM_LANES-1:0][HALF_W-1:0] port_rd
);
    import wsr_pkg::*;

    logic [HALF_W-1:0] store [ENTRIES];

    // Storage update: every enabled writing port stores its half-word.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_LANES; p++) begin
            if (port_en[p] && port_we[p]) begin
                store[port_addr[p]] <= port_wd[p];
            end
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_port
        // Per-port read register: write-first, hold when disabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                port_rd[g] <= '0;
            end else if (port_en[g]) begin
                port_rd[g] <= port_we[g] ? port_wd[g] : store[port_addr[g]];
            end
        end

        // R2: per-port write-first result
        p_port_wfirst_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (port_en[g] && port_we[g]) |=> (port_rd[g] == $past(port_wd[g])));
    end

    // R4: the two ports never write the same internal entry together
    p_no_collide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en[0] && port_we[0] && port_en[1] && port_we[1])
            |-> (port_addr[0] != port_addr[1]));

endmodule

// File: rtl/wsr_lane_map.sv
// Module: maps one wide external access onto the internal dual-port ports.
// Lane k gets bits [k*HALF_W +: HALF_W] of the word. Its internal address is
// the external address with the lane's select bit appended as the LSB.
// The read halves are joined back into the wide word in the same order.
// Assumes WORD_W = NUM_LANES * HALF_W.
module wsr_lane_map #(
    parameter int HALF_W = 36,
    parameter int AW     = 6,
    parameter int IAW    = AW + 1,
    parameter int WORD_W = HALF_W * wsr_pkg::NUM_LANES
) (
    input  logic                                       en,
    input  logic                                       we,
    input  logic [AW-1:0]                              addr,
    input  logic [WORD_W-1:0]                          wdata,
    output logic [WORD_W-1:0]                          rdata,
    output logic [wsr_pkg::NUM_LANES-1:0]              port_en,
    output logic [wsr_pkg::NUM_LANES-1:0]              port_we,
    output logic [wsr_pkg::NUM_LANES-1:0][IAW-1:0]     port_addr,
    output logic [wsr_pkg::NUM_LANES-1:0][HALF_W-1:0]  port_wd,
    input  logic [wsr_pkg::NUM_LANES-1:0][HALF_W-1:0]  port_rd
);
    import wsr_pkg::*;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        // Drive one lane's port request from the shared external access.
        always_comb begin
            port_en[g]   = en;
            port_we[g]   = we;
            port_addr[g] = {addr, lane_sel_bit(g)};
            port_wd[g]   = wdata[g*HALF_W +: HALF_W];
        end

        // Place this lane's read half into the wide word.
        assign rdata[g*HALF_W +: HALF_W] = port_rd[g];
    end

endmodule

// File: rtl/wide_sp_ram.sv
// Module: double-width single-port RAM (top).
// Shows one WORD_W-wide synchronous port. The data is held in a dual-port
// array of HALF_W-wide words, with both ports used in every access.
// Read data is registered and write-first. Enable low blocks writes and
// holds the read data. rst_n (synchronous, active low) clears only the read
// data, not the stored words.
// Assumes WORD_W is even.
module wide_sp_ram #(
    parameter int WORD_W = 72,
    parameter int DEPTH  = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      we,
    input  logic [$clog2(DEPTH)-1:0]  addr,
    input  logic [WORD_W-1:0]         wdata,
    output logic [WORD_W-1:0]         rdata
);
    import wsr_pkg::*;

    localparam int AW      = $clog2(DEPTH);
    localparam int HALF_W  = WORD_W / NUM_LANES;
    localparam int IAW     = AW + 1;
    localparam int ENTRIES = DEPTH * NUM_LANES;

    logic [NUM_LANES-1:0]             port_en;
    logic [NUM_LANES-1:0]             port_we;
    logic [NUM_LANES-1:0][IAW-1:0]    port_addr;
    logic [NUM_LANES-1:0][HALF_W-1:0] port_wd;
    logic [NUM_LANES-1:0][HALF_W-1:0] port_rd;

    wsr_lane_map #(
        .HALF_W (HALF_W),
        .AW     (AW),
        .IAW    (IAW),
        .WORD_W (WORD_W)
    ) u_map (
        .en        (en),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .port_en   (port_en),
        .port_we   (port_we),
        .port_addr (port_addr),
        .port_wd   (port_wd),
        .port_rd   (port_rd)
    );

    wsr_dp_array #(
        .HALF_W  (HALF_W),
        .ENTRIES (ENTRIES),
        .IAW     (IAW)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en   (port_en),
        .port_we   (port_we),
        .port_addr (port_addr),
        .port_wd   (port_wd),
        .port_rd   (port_rd)
    );

    // R2: full-width write-first result on the external port
    p_wfirst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> (rdata == $past(wdata)));

    // R3: enable low holds the read data
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(rdata));

endmodule

// File: tb/sim_wide_sp_ram.sv
// Bench: behavioural wide-word reference model, compared on every clock.
module sim_wide_sp_ram;
    localparam int WORD_W = 72;
    localparam int DEPTH  = 64;
    localparam int AW     = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic              we = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic [WORD_W-1:0] wdata = '0;
    logic [WORD_W-1:0] rdata;

    int errors = 0;
    int checks = 0;

    logic [WORD_W-1:0] ref_mem [DEPTH];
    logic [WORD_W-1:0] ref_rd = '0;

    wide_sp_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [WORD_W-1:0] pat(input int i, input int salt);
        logic [31:0] a = 32'(i) * 32'h9E3779B9 + 32'(salt);
        logic [31:0] b = ~(32'(i) * 32'h85EBCA6B) ^ 32'(salt * 7);
        return {8'(i + salt), a, b};
    endfunction

    task automatic check(input string tag, input logic [WORD_W-1:0] exp);
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%h expected=%h", tag, rdata, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare 1 ns later.
    task automatic step(input logic r, input logic e, input logic w,
                        input int a, input logic [WORD_W-1:0] d, input string tag);
        @(negedge clk);
        rst_n = r; en = e; we = w; addr = AW'(a); wdata = d;
        @(posedge clk);
        if (!r) ref_rd = '0;
        else if (e) begin
            if (w) begin
                ref_mem[a] = d;
                ref_rd = d;
            end else begin
                ref_rd = ref_mem[a];
            end
        end
        #1;
        check(tag, ref_rd);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: rdata=%h expected=run to finish", rdata);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_1234;
        // R5: reset state of the read register
        step(1'b0, 1'b0, 1'b0, 0, '0, "R5 reset");
        step(1'b0, 1'b1, 1'b0, 0, '0, "R5 reset");

        // R4 / R6: fill every word back to back with distinct patterns
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b1, 1'b1, i, pat(i, 1), "R4 fill");
        // R1: read everything back
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b1, 1'b0, i, '0, "R1 read");

        // R4: overwrite one word, neighbours must be untouched
        step(1'b1, 1'b1, 1'b1, 10, {WORD_W{1'b1}}, "R4 write");
        step(1'b1, 1'b1, 1'b0, 9,  '0, "R4 neighbour below");
        step(1'b1, 1'b1, 1'b0, 11, '0, "R4 neighbour above");
        step(1'b1, 1'b1, 1'b0, 10, '0, "R4 target");

        // R2: write-first over a known different word, then read back
        step(1'b1, 1'b1, 1'b0, 20, '0, "R1 before overwrite");
        step(1'b1, 1'b1, 1'b1, 20, pat(20, 99), "R2 write-first");
        step(1'b1, 1'b1, 1'b0, 20, '0, "R2 readback");
        // R2: halves swapped to expose lane mix-ups
        step(1'b1, 1'b1, 1'b1, 0, {36'h0_0000_0000, 36'hF_FFFF_FFFF}, "R2 low half");
        step(1'b1, 1'b1, 1'b1, DEPTH-1, {36'hF_FFFF_FFFF, 36'h0_0000_0000}, "R2 high half");
        step(1'b1, 1'b1, 1'b0, 0, '0, "R4 addr 0");
        step(1'b1, 1'b1, 1'b0, DEPTH-1, '0, "R4 last addr");

        // R3: enable low with write strobe high: no write, read data holds
        step(1'b1, 1'b1, 1'b0, 30, '0, "R1 prime");
        step(1'b1, 1'b0, 1'b1, 30, pat(30, 555), "R3 hold");
        step(1'b1, 1'b0, 1'b0, 31, '0, "R3 hold read");
        step(1'b1, 1'b1, 1'b0, 31, '0, "R1 other");
        step(1'b1, 1'b1, 1'b0, 30, '0, "R3 not written");

        // R6: alternating write / read of the same address every cycle
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b1, 1'b1, 40 + (i % 4), pat(i, 7), "R6 write");
            step(1'b1, 1'b1, 1'b0, 40 + (i % 4), '0, "R6 read");
        end

        // R5: reset mid-run clears rdata, storage survives
        step(1'b0, 1'b1, 1'b0, 5, '0, "R5 mid reset");
        step(1'b1, 1'b1, 1'b0, 5, '0, "R5 survive");

        // R6 / R3: pseudo-random traffic
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(1'b1, lfsr[3:0] != 4'd0, lfsr[5], int'(lfsr[13:8]) % DEPTH,
                 pat(n, int'(lfsr[31:16])), "R6 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule